// File: doc/BRIEF.md
# Paged DRAM Access Sequencer for a 16-bit Memory Region

This block turns single word accesses into the strobe sequences that an asynchronous 16-bit DRAM expects. It serves one address region only. The region number sits in the top bits of the request address. The remaining bits are split into a row and a column that share one set of address pins. A configuration input chooses how many of the low bits form the column. The row comes from the bits directly above them.

The requester holds a request until it sees a one-cycle ready pulse. After a beat, the row stays open. A following access to the same row needs only a new column strobe. An access to another row first lifts the row strobe, and can spend one extra cycle in precharge before the new row is strobed. Each column strobe lasts for a programmed number of extra cycles. It is stretched further while the memory's wait pin is high.

Memory refresh has two modes. In the first, a pulse on the refresh input queues a column-before-row refresh cycle. In the second, a configuration level holds the memory in self refresh.

Top module: `dram_area_ctrl`

## Requirements
- R1: Only requests whose top three address bits equal 2 are served. Any other request leaves the row strobe, both column strobes and ready inactive for as long as it is held.
- R2: With column select code c (0 to 3), the column is the low 8+c bits of the 22-bit region offset and the row is the next 11 bits above it. The row appears on the address pins when the row strobe falls, and the column appears during the column strobe.
- R3: The upper column strobe is driven low only when byte enable bit 1 (data bits 15:8) is set. The lower column strobe is driven low only when byte enable bit 0 (data bits 7:0) is set.
- R4: A column strobe stays low for wait+1 cycles. After the programmed cycles have elapsed, it stays low for one more cycle for each cycle the wait pin is held high.
- R5: Ready pulses high for one cycle, in the last low cycle of the column strobe. On a read, the data on the DRAM data input in that cycle appears on the read data output from the next cycle onward. On a write, write enable is low and the data bus is driven with the write data while the column strobe is low.
- R6: Back-to-back accesses to the open row keep the row strobe low throughout, with the column strobes high for exactly one cycle between beats.
- R7: An access to a different row raises the row strobe for one cycle before the new row strobe, or for two cycles when precharge is enabled.
- R8: A refresh pulse takes priority over a pending access once the current beat ends. The sequence is: both column strobes low with the row strobe high for one cycle, then all three low for one cycle, then all three high.
- R9: While self refresh is selected, the block finishes the current beat, drops both column strobes, then drops the row strobe and holds all three low. It serves no access and ignores refresh pulses until the mode is cleared.
- R10: After reset, the row and column strobes and write enable are high, ready is low and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_col_sel | input | 2 | Column width code: column bits = 8 + code |
| cfg_wait_cnt | input | WAIT_W | Extra column strobe cycles |
| cfg_precharge_en | input | 1 | Insert a precharge cycle before a new row |
| cfg_self_refresh | input | 1 | Select and hold self refresh |
| refresh_due | input | 1 | One-cycle request for a column-before-row refresh |
| req_valid | input | 1 | Access request, held until ready |
| req_addr | input | ADDR_W | Word address; top AREA_W bits select the region |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 16 | Data driven to the memory |
| dram_dq_oe | output | 1 | Data bus output enable |
| dram_dq_in | input | 16 | Data returned by the memory |
| dram_wait | input | 1 | Wait request from the memory side |

## Verification
The bench uses the default parameters: an 11-bit multiplexed address, a 3-bit region field and a 3-bit wait count. With these, all four column splits can be reached using row values whose upper bits are non-zero, so a wrong slice shows up on the pins. The 3-bit counter lets programmed waits of 0, 1 and 3 be combined with a held wait pin in short runs. The memory model returns data computed from the column address, so both a read capture that is a beat late and a wrong column split produce wrong data.

// File: rtl/dram_area_pkg.sv
// Package: shared constants and the sequencer state type for the DRAM region controller.
// Assumes a 16-bit data bus with two byte lanes.
package dram_area_pkg;
    localparam int COL_BASE    = 8;   // narrowest column split
    localparam int COL_CHOICES = 4;   // splits 8, 9, 10, 11
    localparam int DATA_W      = 16;

    typedef enum logic [3:0] {
        ST_IDLE, // row strobe high, page closed
        ST_PRE,  // precharge cycle, row strobe high
        ST_ROW,  // row strobe low with row address
        ST_COL,  // column strobe low
        ST_PAGE, // row open, column strobes high
        ST_RCAS, // refresh: column strobes first
        ST_RRAS, // refresh: row strobe joins
        ST_SCAS, // self refresh entry: column strobes first
        ST_SELF  // self refresh hold
    } dram_seq_e;
endpackage

// File: rtl/dram_addr_mux.sv
// Module: splits a region offset into row and column for the selected column width.
// Assumes OFS_W = COL_BASE + COL_CHOICES - 1 + MUX_W, so every offset bit feeds some split.
module dram_addr_mux
    import dram_area_pkg::*;
#(
    parameter int MUX_W = 11,
    localparam int OFS_W = COL_BASE + COL_CHOICES - 1 + MUX_W
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       col_sel,
    output logic [MUX_W-1:0] row,
    output logic [MUX_W-1:0] col
);
    logic [MUX_W-1:0] row_opt [COL_CHOICES];
    logic [MUX_W-1:0] col_opt [COL_CHOICES];

    // One precomputed slice pair per supported column width.
    for (genvar g = 0; g < COL_CHOICES; g++) begin : g_split
        localparam logic [MUX_W-1:0] COL_MASK = MUX_W'((1 << (COL_BASE + g)) - 1);
        assign row_opt[g] = ofs[COL_BASE + g +: MUX_W];
        assign col_opt[g] = ofs[MUX_W-1:0] & COL_MASK;
    end

    // Select the slice pair named by the configuration code.
    always_comb begin
        row = row_opt[col_sel];
        col = col_opt[col_sel];
    end
endmodule

// File: rtl/dram_cas_timer.sv
// Module: counts the programmed column-strobe wait cycles.
// Assumes load is raised in the cycle before the column strobe starts.
module dram_cas_timer #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              busy
);
    logic [WAIT_W-1:0] cnt_q;

    // Load on column entry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= cfg_wait;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/dram_seq_fsm.sv
// Module: strobe sequencer for access beats, page hits, precharge and both refresh modes.
// Assumes area_req already includes the region decode, and row_same compares against the open row.
module dram_seq_fsm
    import dram_area_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      area_req,
    input  logic      row_same,
    input  logic      cfg_precharge_en,
    input  logic      cfg_self_refresh,
    input  logic      ref_any,
    input  logic      wait_busy,
    input  logic      dram_wait,
    output dram_seq_e state,
    output dram_seq_e state_nxt,
    output logic      accept,
    output logic      load_wait,
    output logic      final_beat,
    output logic      start_cbr
);
    logic cbr_go;
    assign cbr_go = ref_any && !cfg_self_refresh;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state: refresh first, then self refresh, then the access.
    always_comb begin
        state_nxt  = state;
        accept     = 1'b0;
        final_beat = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cbr_go)                state_nxt = ST_RCAS;
                else if (cfg_self_refresh) state_nxt = ST_SCAS;
                else if (area_req) begin
                    accept    = 1'b1;
                    state_nxt = cfg_precharge_en ? ST_PRE : ST_ROW;
                end
            end
            ST_PRE:  state_nxt = ST_ROW;
            ST_ROW:  state_nxt = ST_COL;
            ST_COL: begin
                if (!wait_busy && !dram_wait) begin
                    final_beat = 1'b1;
                    state_nxt  = ST_PAGE;
                end
            end
            ST_PAGE: begin
                if (cbr_go || cfg_self_refresh) state_nxt = ST_IDLE;
                else if (area_req) begin
                    if (row_same) begin
                        accept    = 1'b1;
                        state_nxt = ST_COL;
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end
            end
            ST_RCAS: state_nxt = ST_RRAS;
            ST_RRAS: state_nxt = ST_IDLE;
            ST_SCAS: state_nxt = ST_SELF;
            ST_SELF: if (!cfg_self_refresh) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign load_wait = (state_nxt == ST_COL) && (state != ST_COL);
    assign start_cbr = (state == ST_IDLE) && cbr_go;

    AST_ROW_BEFORE_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW) |=> (state == ST_COL)) else $error("row phase not followed by column"); // R2

    AST_PAGE_HIT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAGE && area_req && row_same && !ref_any && !cfg_self_refresh)
        |=> (state == ST_COL)) else $error("page hit did not stay in row"); // R6
endmodule

// File: rtl/dram_area_ctrl.sv
// Module: top of the DRAM region controller; decodes the region, latches the beat and drives the pins.
// Assumes the requester holds req_valid and its fields stable until req_ready.
module dram_area_ctrl
    import dram_area_pkg::*;
#(
    parameter int MUX_W   = 11,
    parameter int AREA_W  = 3,
    parameter int AREA_ID = 2,
    parameter int WAIT_W  = 3,
    localparam int OFS_W  = COL_BASE + COL_CHOICES - 1 + MUX_W,
    localparam int ADDR_W = AREA_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_col_sel,
    input  logic [WAIT_W-1:0] cfg_wait_cnt,
    input  logic              cfg_precharge_en,
    input  logic              cfg_self_refresh,
    input  logic              refresh_due,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_ucas_n,
    output logic              dram_lcas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in,
    input  logic              dram_wait
);
    logic              area_hit, area_req, row_same, ref_pend, ref_any;
    logic              wait_busy, accept, load_wait, final_beat, start_cbr;
    logic [MUX_W-1:0]  req_row, req_col, row_q, col_q;
    logic              we_q;
    logic [1:0]        be_q;
    logic [DATA_W-1:0] wd_q;
    dram_seq_e         fsm_state, fsm_next;
    logic              in_col, ras_on, ref_cas;

    assign area_hit = (req_addr[ADDR_W-1 -: AREA_W] == AREA_W'(AREA_ID));
    assign area_req = req_valid && area_hit;
    assign row_same = (req_row == row_q);
    assign ref_any  = ref_pend || refresh_due;

    dram_addr_mux #(.MUX_W(MUX_W)) u_mux (
        .ofs     (req_addr[OFS_W-1:0]),
        .col_sel (cfg_col_sel),
        .row     (req_row),
        .col     (req_col)
    );

    dram_cas_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_wait),
        .cfg_wait (cfg_wait_cnt),
        .busy     (wait_busy)
    );

    dram_seq_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .area_req         (area_req),
        .row_same         (row_same),
        .cfg_precharge_en (cfg_precharge_en),
        .cfg_self_refresh (cfg_self_refresh),
        .ref_any          (ref_any),
        .wait_busy        (wait_busy),
        .dram_wait        (dram_wait),
        .state            (fsm_state),
        .state_nxt        (fsm_next),
        .accept           (accept),
        .load_wait        (load_wait),
        .final_beat       (final_beat),
        .start_cbr        (start_cbr)
    );

    // Hold a refresh pulse until its sequence starts; self refresh makes it moot.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_self_refresh || start_cbr) ref_pend <= 1'b0;
        else if (refresh_due)                       ref_pend <= 1'b1;
    end

    // Latch the accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            we_q  <= 1'b0;
            be_q  <= '0;
            wd_q  <= '0;
        end else if (accept) begin
            row_q <= req_row;
            col_q <= req_col;
            we_q  <= req_we;
            be_q  <= req_be;
            wd_q  <= req_wdata;
        end
    end

    // Capture read data in the final column cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rsp_rdata <= '0;
        else if (final_beat && !we_q) rsp_rdata <= dram_dq_in;
    end

    // Pin decode from the sequencer state.
    always_comb begin
        in_col  = (fsm_state == ST_COL);
        ref_cas = (fsm_state == ST_RCAS) || (fsm_state == ST_RRAS) ||
                  (fsm_state == ST_SCAS) || (fsm_state == ST_SELF);
        ras_on  = (fsm_state == ST_ROW) || in_col || (fsm_state == ST_PAGE) ||
                  (fsm_state == ST_RRAS) || (fsm_state == ST_SELF);
        dram_ras_n  = !ras_on;
        dram_ucas_n = !((in_col && be_q[1]) || ref_cas);
        dram_lcas_n = !((in_col && be_q[0]) || ref_cas);
        dram_addr   = (in_col || fsm_state == ST_PAGE) ? col_q : row_q;
        dram_we_n   = !(in_col && we_q);
        dram_dq_oe  = in_col && we_q;
        dram_dq_out = wd_q;
        req_ready   = final_beat;
    end

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && req_valid && !area_hit && !ref_any && !cfg_self_refresh)
        |=> (dram_ras_n && dram_ucas_n && dram_lcas_n)) else $error("foreign region served"); // R1

    AST_WAIT_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && cfg_wait_cnt != '0) |-> $past(fsm_state == ST_COL))
        else $error("ready without programmed wait"); // R4

    AST_READY_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !dram_ras_n) else $error("ready with row closed"); // R5

    AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_ucas_n && dram_lcas_n && cfg_precharge_en)
        |-> $past(dram_ras_n, 2)) else $error("precharge cycle missing"); // R7

    AST_CAS_THEN_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n && !dram_lcas_n) |=> (!dram_ras_n && !dram_lcas_n))
        else $error("refresh order broken"); // R8
endmodule

// File: tb/dram_area_ctrl_bench.sv
module dram_area_ctrl_bench;
    localparam int MUX_W  = 11;
    localparam int ADDR_W = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_col_sel = 2'd0;
    logic [2:0]        cfg_wait_cnt = 3'd1;
    logic              cfg_precharge_en = 1'b1;
    logic              cfg_self_refresh = 1'b0;
    logic              refresh_due = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_we = 1'b0;
    logic [1:0]        req_be = 2'b11;
    logic [15:0]       req_wdata = '0;
    logic              req_ready;
    logic [15:0]       rsp_rdata;
    logic [MUX_W-1:0]  dram_addr;
    logic              dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_dq_oe;
    logic [15:0]       dram_dq_out, dram_dq_in;
    logic              dram_wait;

    int n_tests = 0;
    int n_fail  = 0;
    int pin_extra = 0;
    int cas_run = 0;

    always #2 clk = ~clk;

    dram_area_ctrl u_dram_area_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_col_sel(cfg_col_sel), .cfg_wait_cnt(cfg_wait_cnt),
        .cfg_precharge_en(cfg_precharge_en), .cfg_self_refresh(cfg_self_refresh),
        .refresh_due(refresh_due), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in),
        .dram_wait(dram_wait)
    );

    function automatic logic [15:0] mem_word(input logic [MUX_W-1:0] a);
        return ({5'd0, a} * 16'd7) + 16'h1234;
    endfunction

    assign dram_dq_in = mem_word(dram_addr);
    assign dram_wait  = (cas_run != 0) && (cas_run <= int'(cfg_wait_cnt) + pin_extra);

    typedef struct {
        logic [10:0] row;
        logic [10:0] col;
        logic [1:0]  be;
        logic        we;
        logic [15:0] wd;
        int          len;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Column strobe run length, updated just after each edge.
    always @(posedge clk) begin
        #1;
        if (!dram_ucas_n || !dram_lcas_n) cas_run = cas_run + 1;
        else                              cas_run = 0;
    end

    // Monitor and scoreboard.
    int ras_falls = 0, ras_hi_run = 0, last_ras_hi = 0;
    int cas_hi_run = 0, last_cas_hi = 0;
    int ready_cnt = 0, cbr_full = 0, ready_at_cbr = -1;
    logic [10:0] row_seen = '0;
    bit prev_ras = 1'b1, prev_cas = 1'b0;
    bit h1_ras = 1'b1, h1_cas = 1'b0, h2_ras = 1'b1, h2_cas = 1'b0;
    bit rd_pend = 1'b0;
    logic [15:0] rd_exp = '0;

    always @(negedge clk) begin
        bit   cas_low;
        exp_t it;
        if (rst_n) begin
            cas_low = !dram_ucas_n || !dram_lcas_n;
            if (!dram_ras_n && prev_ras) begin
                ras_falls++;
                last_ras_hi = ras_hi_run;
                if (!cas_low) row_seen = dram_addr;
            end
            ras_hi_run = dram_ras_n ? ras_hi_run + 1 : 0;
            if (cas_low && !prev_cas) last_cas_hi = cas_hi_run;
            cas_hi_run = cas_low ? 0 : cas_hi_run + 1;
            if (h2_ras && h2_cas && !h1_ras && h1_cas && dram_ras_n && !cas_low) begin
                cbr_full++;
                ready_at_cbr = ready_cnt;
            end
            h2_ras = h1_ras; h2_cas = h1_cas;
            h1_ras = dram_ras_n; h1_cas = cas_low;
            prev_ras = dram_ras_n; prev_cas = cas_low;

            if (rd_pend) begin
                chk(rsp_rdata == rd_exp, "R5 read data", rsp_rdata, rd_exp);
                rd_pend = 1'b0;
            end
            if (req_ready) begin
                ready_cnt++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected ready", 1, 0);
                end else begin
                    it = sb_q.pop_front();
                    chk(row_seen == it.row, "R2 row on pins", row_seen, it.row);
                    chk(dram_addr == it.col, "R2 column on pins", dram_addr, it.col);
                    chk(dram_ucas_n == !it.be[1], "R3 upper strobe", dram_ucas_n, !it.be[1]);
                    chk(dram_lcas_n == !it.be[0], "R3 lower strobe", dram_lcas_n, !it.be[0]);
                    chk(cas_run == it.len, "R4 strobe length", cas_run, it.len);
                    if (it.we) begin
                        chk(!dram_we_n && dram_dq_oe, "R5 write enable", {dram_we_n, dram_dq_oe}, 2'b01);
                        chk(dram_dq_out == it.wd, "R5 write data", dram_dq_out, it.wd);
                    end else begin
                        chk(dram_we_n && !dram_dq_oe, "R5 read bus idle", {dram_we_n, dram_dq_oe}, 2'b10);
                        rd_pend = 1'b1;
                        rd_exp  = mem_word(it.col);
                    end
                end
            end
        end
    end

    task automatic start_access(input int code, input int row, input int col,
                                input bit we, input logic [1:0] be, input logic [15:0] wd);
        exp_t it;
        logic [21:0] ofs;
        ofs = 22'((row << (8 + code)) | col);
        it.row = 11'(row); it.col = 11'(col); it.be = be; it.we = we; it.wd = wd;
        it.len = int'(cfg_wait_cnt) + pin_extra + 1;
        sb_q.push_back(it);
        req_addr  = {3'd2, ofs};
        req_we    = we;
        req_be    = be;
        req_wdata = wd;
        req_valid = 1'b1;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!req_ready);
    endtask

    task automatic access(input int code, input int row, input int col,
                          input bit we, input logic [1:0] be, input logic [15:0] wd);
        start_access(code, row, col, we, be, wd);
        wait_ready();
    endtask

    task automatic go_idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int f0, rc, cb;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(dram_ras_n == 1'b1, "R10 row strobe idle", dram_ras_n, 1);
        chk(dram_ucas_n && dram_lcas_n, "R10 column strobes idle", {dram_ucas_n, dram_lcas_n}, 2'b11);
        chk(req_ready == 1'b0, "R10 ready idle", req_ready, 0);
        chk(!dram_dq_oe && dram_we_n, "R10 bus idle", {dram_dq_oe, dram_we_n}, 2'b01);

        // R1 foreign region held for a while
        f0 = ras_falls; rc = ready_cnt;
        req_addr = {3'd5, 22'h00ABCD}; req_we = 1'b0; req_be = 2'b11; req_valid = 1'b1;
        repeat (12) @(negedge clk);
        chk(ras_falls == f0, "R1 no row strobe", ras_falls, f0);
        chk(ready_cnt == rc, "R1 no ready", ready_cnt, rc);
        chk(dram_ucas_n && dram_lcas_n, "R1 no column strobe", {dram_ucas_n, dram_lcas_n}, 2'b11);
        go_idle(2);

        // R2 R3 R4 R5 first read, 8-bit column
        access(0, 'h015, 'h3C, 1'b0, 2'b11, 16'h0);
        // R6 burst on the open row
        f0 = ras_falls;
        access(0, 'h015, 'h3D, 1'b0, 2'b01, 16'h0);
        access(0, 'h015, 'h3E, 1'b1, 2'b10, 16'hBEEF);
        access(0, 'h015, 'hFF, 1'b0, 2'b11, 16'h0);
        chk(ras_falls == f0, "R6 row held over burst", ras_falls, f0);
        chk(last_cas_hi == 1, "R6 one-cycle column gap", last_cas_hi, 1);
        go_idle(3);

        // R7 row change with and without precharge
        access(0, 'h2A0, 'h01, 1'b1, 2'b11, 16'h1357);
        chk(last_ras_hi == 2, "R7 gap with precharge", last_ras_hi, 2);
        go_idle(3);
        cfg_precharge_en = 1'b0;
        access(0, 'h011, 'h80, 1'b0, 2'b11, 16'h0);
        chk(last_ras_hi == 1, "R7 gap without precharge", last_ras_hi, 1);
        go_idle(3);

        // R4 programmed wait plus wait pin, then zero wait
        cfg_wait_cnt = 3'd3; pin_extra = 2;
        access(0, 'h011, 'h81, 1'b0, 2'b11, 16'h0);
        go_idle(3);
        cfg_wait_cnt = 3'd0; pin_extra = 0;
        access(0, 'h011, 'h82, 1'b0, 2'b10, 16'h0);
        access(0, 'h011, 'h83, 1'b1, 2'b01, 16'h00A5);
        go_idle(3);

        // R2 wider column splits
        cfg_wait_cnt = 3'd1; cfg_precharge_en = 1'b1;
        cfg_col_sel = 2'd1; @(negedge clk);
        access(1, 'h101, 'h1AB, 1'b0, 2'b11, 16'h0);
        go_idle(3);
        cfg_col_sel = 2'd2; @(negedge clk);
        access(2, 'h202, 'h3C5, 1'b0, 2'b11, 16'h0);
        go_idle(3);
        cfg_col_sel = 2'd3; @(negedge clk);
        access(3, 'h333, 'h7FE, 1'b0, 2'b11, 16'h0);
        go_idle(3);

        // R8 refresh pulse together with a same-row request
        rc = ready_cnt; cb = cbr_full;
        refresh_due = 1'b1;
        start_access(3, 'h333, 'h010, 1'b0, 2'b11, 16'h0);
        @(negedge clk);
        refresh_due = 1'b0;
        wait_ready();
        chk(cbr_full == cb + 1, "R8 refresh sequence seen", cbr_full, cb + 1);
        chk(ready_at_cbr == rc, "R8 refresh before access", ready_at_cbr, rc);
        go_idle(3);

        // R9 self refresh holds strobes and blocks accesses
        cfg_self_refresh = 1'b1;
        repeat (10) @(negedge clk);
        chk(!dram_ras_n && !dram_ucas_n && !dram_lcas_n, "R9 strobes held low",
            {dram_ras_n, dram_ucas_n, dram_lcas_n}, 3'b000);
        rc = ready_cnt; cb = cbr_full;
        start_access(3, 'h333, 'h011, 1'b0, 2'b11, 16'h0);
        refresh_due = 1'b1;
        @(negedge clk);
        refresh_due = 1'b0;
        repeat (10) @(negedge clk);
        chk(ready_cnt == rc, "R9 no access served", ready_cnt, rc);
        chk(!dram_ras_n, "R9 still in self refresh", dram_ras_n, 0);
        cfg_self_refresh = 1'b0;
        wait_ready();
        chk(cbr_full == cb, "R9 refresh pulse ignored", cbr_full, cb);
        go_idle(4);
        chk(sb_q.size() == 0, "R5 all beats completed", sb_q.size(), 0);
        finish_run();
    end
endmodule